// File: doc/BRIEF.md
# Linked Descriptor Field Fetcher

This block drives the settings of one display plane from a chain of 16-word descriptors held in memory, so no CPU writes the plane's shadow registers. At every vertical sync it takes the current next-node pointer and reads the 16 words of the descriptor found there. Once all 16 words have arrived, it loads that descriptor's position, size, pixel address and pitch into the active plane outputs in a single cycle. The descriptor's own next-node word becomes the pointer for the following sync.

Two descriptors that point at each other alternate between the top and bottom fields with no further software action. Software swaps buffers by rewriting one pointer. A zero pointer blanks the plane. So does a descriptor whose priority word requests that it be ignored. A misaligned pointer is refused, and a sync that arrives before a fetch has finished is reported as an underflow. Fetching the pixels themselves is left to other logic.

Top module: `ldf_fetcher`

## Requirements
- R1: After reset all active outputs are zero, `act_en`, `underflow` and `ptr_err` are low and `mem_req` is low.
- R2: At a vsync with a usable pointer (non-zero, bits 3:0 all zero), the block issues 16 word reads at pointer + 4*i for i = 0..15, in increasing order. `mem_req` and `mem_addr` are held until `mem_valid` accepts each word.
- R3: After the 16th word, all active outputs change together in one cycle. Origin line and pixel come from word 3 (bits 31:16 and 15:0). Stop line and pixel come from word 4 with the same packing. Pixel address is word 5, pitch is word 6, and height and width come from word 7 (bits 31:16 and 15:0). All other words are ignored.
- R4: Width and height above 0x7FF are driven as 0x7FF. Values up to 0x7FF pass through unchanged.
- R5: A commit sets `act_en` to 1 exactly when bits 1:0 of word 13 (priority) are both zero.
- R6: At a commit, word 9 becomes the next-node pointer, which the next vsync fetches. Two descriptors that link to each other alternate on every sync.
- R7: A vsync that finds a zero pointer clears `act_en`, starts no fetch, and keeps all other active outputs.
- R8: A vsync that finds a non-zero pointer with bits 3:0 not all zero sets `ptr_err`, starts no fetch, and keeps all active outputs including `act_en`. Both status flags clear at the next commit.
- R9: A write to the next-node register takes effect at once when no fetch is pending. A write made during a fetch, while a descriptor waits, or in a vsync cycle is held and used at the following vsync, in place of the linked pointer.
- R10: A descriptor with bit 31 of word 0 set is not committed when its fetch ends. It is committed at the next vsync, and that vsync starts no fetch.
- R11: A vsync during a fetch sets `underflow`, drops the partial descriptor without touching the active outputs, and restarts the fetch from the pointer as chosen at any vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vsync | input | 1 | One-cycle vertical sync pulse |
| nn_wr | input | 1 | Write strobe for the next-node register |
| nn_wdata | input | 32 | Next-node pointer value to write |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid, accepts the current request |
| mem_data | input | 32 | Read data word |
| act_x0 | output | 16 | Active origin pixel |
| act_y0 | output | 16 | Active origin line |
| act_x1 | output | 16 | Active stop pixel |
| act_y1 | output | 16 | Active stop line |
| act_w | output | 16 | Active width, clamped |
| act_h | output | 16 | Active height, clamped |
| act_pix_addr | output | 32 | Active pixel memory address |
| act_pitch | output | 32 | Active memory pitch |
| act_en | output | 1 | Plane displayed |
| underflow | output | 1 | Sync arrived during a fetch |
| ptr_err | output | 1 | Misaligned pointer refused |

## Verification
A wrong word counter or base register shows up on `mem_addr` within one accepted read. It also lands in the wrong active field about twenty cycles after the sync. A wrong next-node register shows only at the following vsync: the fetch then starts from the wrong descriptor, and the plane shows the wrong settings one frame late. The bench therefore follows every chain for several syncs. A state machine stuck in its waiting state shows as a commit that never happens, or as a request that appears at a sync where none should.

// File: rtl/ldf_fetcher.sv
module ldf_fetcher #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CRD_W      = 16,
  parameter int DESC_WORDS = 16,
  parameter int ALIGN_BITS = 4,
  parameter logic [CRD_W-1:0] SIZE_MAX = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              nn_wr,
  input  logic [ADDR_W-1:0] nn_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  output logic [CRD_W-1:0]  act_x0,
  output logic [CRD_W-1:0]  act_y0,
  output logic [CRD_W-1:0]  act_x1,
  output logic [CRD_W-1:0]  act_y1,
  output logic [CRD_W-1:0]  act_w,
  output logic [CRD_W-1:0]  act_h,
  output logic [ADDR_W-1:0] act_pix_addr,
  output logic [ADDR_W-1:0] act_pitch,
  output logic              act_en,
  output logic              underflow,
  output logic              ptr_err
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] W_CTL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_ORG  = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_STP  = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_PIX  = IDX_W'(5);
  localparam logic [IDX_W-1:0] W_PIT  = IDX_W'(6);
  localparam logic [IDX_W-1:0] W_SIZ  = IDX_W'(7);
  localparam logic [IDX_W-1:0] W_NXT  = IDX_W'(9);
  localparam logic [IDX_W-1:0] W_PRI  = IDX_W'(13);
  localparam logic [IDX_W-1:0] W_LAST = IDX_W'(DESC_WORDS-1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} st_t;

  st_t               state;
  logic [ADDR_W-1:0] base, nn_reg, pend;
  logic              pend_v;
  logic [IDX_W-1:0]  idx;
  logic              sh_defer;
  logic [1:0]        sh_pri;
  logic [DATA_W-1:0] sh_org, sh_stp, sh_pix, sh_pit, sh_siz, sh_nxt;

  logic [ADDR_W-1:0] sel_ptr;
  logic              fetch_end, commit_now, eval_now;

  assign sel_ptr    = pend_v ? pend : nn_reg;
  assign eval_now   = vsync && (state != S_WAIT);
  assign fetch_end  = (state == S_FETCH) && mem_valid && !vsync && (idx == W_LAST);
  assign commit_now = (fetch_end && !sh_defer) || ((state == S_WAIT) && vsync);
  assign mem_req    = (state == S_FETCH);
  assign mem_addr   = base + (ADDR_W'(idx) << 2);

  function automatic logic [CRD_W-1:0] clampv(input logic [CRD_W-1:0] v);
    return (v > SIZE_MAX) ? SIZE_MAX : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      base   <= '0;
      nn_reg <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
      idx    <= '0;
    end else begin
      if (eval_now) begin
        pend_v <= 1'b0;
        if (pend_v) nn_reg <= pend;
        if (sel_ptr == '0 || sel_ptr[ALIGN_BITS-1:0] != '0) begin
          state <= S_IDLE;
        end else begin
          base  <= sel_ptr;
          idx   <= '0;
          state <= S_FETCH;
        end
      end else if (state == S_FETCH && mem_valid) begin
        idx <= idx + 1'b1;
        if (idx == W_LAST) begin
          nn_reg <= sh_nxt;
          state  <= sh_defer ? S_WAIT : S_IDLE;
        end
      end else if (state == S_WAIT && vsync) begin
        state  <= S_IDLE;
        pend_v <= 1'b0;
        nn_reg <= pend_v ? pend : sh_nxt;
      end
      if (nn_wr) begin
        if (state == S_IDLE && !vsync) begin
          nn_reg <= nn_wdata;
        end else begin
          pend   <= nn_wdata;
          pend_v <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_defer <= 1'b0;
      sh_pri   <= '0;
      sh_org   <= '0;
      sh_stp   <= '0;
      sh_pix   <= '0;
      sh_pit   <= '0;
      sh_siz   <= '0;
      sh_nxt   <= '0;
    end else if (state == S_FETCH && mem_valid && !vsync) begin
      case (idx)
        W_CTL: sh_defer <= mem_data[DATA_W-1];
        W_ORG: sh_org   <= mem_data;
        W_STP: sh_stp   <= mem_data;
        W_PIX: sh_pix   <= mem_data;
        W_PIT: sh_pit   <= mem_data;
        W_SIZ: sh_siz   <= mem_data;
        W_NXT: sh_nxt   <= mem_data;
        W_PRI: sh_pri   <= mem_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_x0       <= '0;
      act_y0       <= '0;
      act_x1       <= '0;
      act_y1       <= '0;
      act_w        <= '0;
      act_h        <= '0;
      act_pix_addr <= '0;
      act_pitch    <= '0;
      act_en       <= 1'b0;
      underflow    <= 1'b0;
      ptr_err      <= 1'b0;
    end else if (commit_now) begin
      act_x0       <= sh_org[CRD_W-1:0];
      act_y0       <= sh_org[DATA_W-1 -: CRD_W];
      act_x1       <= sh_stp[CRD_W-1:0];
      act_y1       <= sh_stp[DATA_W-1 -: CRD_W];
      act_w        <= clampv(sh_siz[CRD_W-1:0]);
      act_h        <= clampv(sh_siz[DATA_W-1 -: CRD_W]);
      act_pix_addr <= sh_pix;
      act_pitch    <= sh_pit;
      act_en       <= (sh_pri == 2'b00);
      underflow    <= 1'b0;
      ptr_err      <= 1'b0;
    end else if (eval_now) begin
      if (state == S_FETCH) underflow <= 1'b1;
      if (sel_ptr == '0) act_en <= 1'b0;
      else if (sel_ptr[ALIGN_BITS-1:0] != '0) ptr_err <= 1'b1;
    end
  end
endmodule

module ldf_fetcher_chk #(
  parameter int ADDR_W = 32,
  parameter int CRD_W  = 16,
  parameter logic [CRD_W-1:0] SIZE_MAX = 16'h07FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CRD_W-1:0]  act_w,
  input logic [CRD_W-1:0]  act_h,
  input logic [ADDR_W-1:0] act_pix_addr,
  input logic              underflow,
  input logic              ptr_err
);
  // R4
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w <= SIZE_MAX) && (act_h <= SIZE_MAX));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && !mem_valid) |=> ($stable(act_pix_addr) && $stable(act_w) && $stable(act_h)));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && !vsync) |=> (mem_req && $stable(mem_addr)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !vsync) |=> (!mem_req || (mem_addr == $past(mem_addr) + 4)));

  // R11
  uf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> ($past(vsync) && $past(mem_req)));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_err) |-> $past(vsync));
endmodule

bind ldf_fetcher ldf_fetcher_chk #(.ADDR_W(ADDR_W), .CRD_W(CRD_W), .SIZE_MAX(SIZE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .mem_req(mem_req), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .act_w(act_w), .act_h(act_h), .act_pix_addr(act_pix_addr),
  .underflow(underflow), .ptr_err(ptr_err)
);

// File: tb/ldf_fetcher_tb.sv
module ldf_fetcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync = 1'b0;
  logic        nn_wr = 1'b0;
  logic [31:0] nn_wdata = '0;
  logic        mem_req, mem_valid;
  logic [31:0] mem_addr, mem_data;
  logic [15:0] act_x0, act_y0, act_x1, act_y1, act_w, act_h;
  logic [31:0] act_pix_addr, act_pitch;
  logic        act_en, underflow, ptr_err;

  logic [31:0] mem [0:127];
  logic        mem_hold = 1'b0;
  logic        stall_mode = 1'b0;
  logic [31:0] cyc = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] e_ctl [4];
  logic [31:0] e_org [4];
  logic [31:0] e_stp [4];
  logic [31:0] e_pix [4];
  logic [31:0] e_pit [4];
  logic [31:0] e_siz [4];
  logic [31:0] e_nxt [4];
  logic [31:0] e_pri [4];

  bit          mon_on = 0;
  logic [31:0] mon_exp = '0;
  int          mon_cnt = 0;
  int          mon_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_valid = mem_req && !mem_hold && !(stall_mode && cyc[0]);
  assign mem_data  = mem[mem_addr[8:2]];

  ldf_fetcher u_dut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .nn_wr(nn_wr), .nn_wdata(nn_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .act_x0(act_x0), .act_y0(act_y0), .act_x1(act_x1), .act_y1(act_y1),
    .act_w(act_w), .act_h(act_h), .act_pix_addr(act_pix_addr), .act_pitch(act_pitch),
    .act_en(act_en), .underflow(underflow), .ptr_err(ptr_err)
  );

  always @(negedge clk) begin
    if (mon_on && mem_req && mem_valid) begin
      if (mem_addr != mon_exp) mon_bad++;
      mon_exp = mon_exp + 4;
      mon_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] clampx(input logic [15:0] v);
    return (v > 16'h07FF) ? 16'h07FF : v;
  endfunction

  function automatic logic [31:0] dbase(input int k);
    return 32'(64 * (k + 1));
  endfunction

  task automatic put_desc(input int k);
    int w0;
    w0 = (k + 1) * 16;
    for (int i = 0; i < 16; i++) mem[w0 + i] = 32'hDEAD_0000 | 32'(i) | (32'(k) << 8);
    mem[w0 + 0]  = e_ctl[k];
    mem[w0 + 3]  = e_org[k];
    mem[w0 + 4]  = e_stp[k];
    mem[w0 + 5]  = e_pix[k];
    mem[w0 + 6]  = e_pit[k];
    mem[w0 + 7]  = e_siz[k];
    mem[w0 + 9]  = e_nxt[k];
    mem[w0 + 13] = e_pri[k];
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_vs();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  task automatic wr_nn(input logic [31:0] v);
    @(negedge clk) begin nn_wr = 1'b1; nn_wdata = v; end
    @(negedge clk) nn_wr = 1'b0;
  endtask

  task automatic chk_act(input string tag, input int k);
    chk({tag, " x0"}, {16'h0, act_x0}, {16'h0, e_org[k][15:0]});
    chk({tag, " y0"}, {16'h0, act_y0}, {16'h0, e_org[k][31:16]});
    chk({tag, " x1"}, {16'h0, act_x1}, {16'h0, e_stp[k][15:0]});
    chk({tag, " y1"}, {16'h0, act_y1}, {16'h0, e_stp[k][31:16]});
    chk({tag, " w"}, {16'h0, act_w}, {16'h0, clampx(e_siz[k][15:0])});
    chk({tag, " h"}, {16'h0, act_h}, {16'h0, clampx(e_siz[k][31:16])});
    chk({tag, " pix"}, act_pix_addr, e_pix[k]);
    chk({tag, " pitch"}, act_pitch, e_pit[k]);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hBAD0_0000 | 32'(i);
    for (int k = 0; k < 4; k++) begin
      e_ctl[k] = 32'h0000_0005;
      e_org[k] = {16'(20 + k), 16'(10 + k)};
      e_stp[k] = {16'(200 + k), 16'(300 + k)};
      e_pix[k] = 32'h1000_0000 + 32'(k) * 32'h0001_0A00;
      e_pit[k] = 32'h0000_0A00 + 32'(k) * 32'h40;
      e_siz[k] = {16'(100 + k), 16'(290 + k)};
      e_pri[k] = 32'h0;
    end
    e_nxt[0] = dbase(1);
    e_nxt[1] = dbase(0);
    e_nxt[2] = dbase(1);
    e_nxt[3] = dbase(0);
    e_ctl[3] = 32'h8000_0005;
    for (int k = 0; k < 4; k++) put_desc(k);

    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1
    chk("R1 en", {31'h0, act_en}, 32'h0);
    chk("R1 uf", {31'h0, underflow}, 32'h0);
    chk("R1 err", {31'h0, ptr_err}, 32'h0);
    chk("R1 req", {31'h0, mem_req}, 32'h0);
    chk("R1 pix", act_pix_addr, 32'h0);
    chk("R1 w", {16'h0, act_w}, 32'h0);

    // R2 with stalls, R3 field mapping, R6 alternation
    wr_nn(dbase(0));
    stall_mode = 1'b1;
    mon_exp = dbase(0); mon_cnt = 0; mon_bad = 0; mon_on = 1;
    pulse_vs();
    wait_n(60);
    mon_on = 0;
    stall_mode = 1'b0;
    chk("R2 word count", 32'(mon_cnt), 32'd16);
    chk("R2 address order", 32'(mon_bad), 32'd0);
    chk_act("R3 first", 0);
    chk("R5 en", {31'h0, act_en}, 32'h1);
    pulse_vs(); wait_n(50);
    chk_act("R6 partner", 1);
    pulse_vs(); wait_n(50);
    chk_act("R6 back", 0);
    pulse_vs(); wait_n(50);
    chk_act("R6 again", 1);

    // R9: write during fetch is held for the following vsync
    wr_nn(dbase(0));
    pulse_vs();
    wait_n(3);
    wr_nn(dbase(2));
    wait_n(50);
    chk_act("R9 current", 0);
    pulse_vs(); wait_n(50);
    chk_act("R9 pending used", 2);

    // R10: deferred descriptor
    wr_nn(dbase(3));
    pulse_vs(); wait_n(50);
    chk_act("R10 held", 2);
    chk("R10 no req", {31'h0, mem_req}, 32'h0);
    pulse_vs(); wait_n(2);
    chk_act("R10 commit", 3);
    chk("R10 no fetch", {31'h0, mem_req}, 32'h0);
    pulse_vs(); wait_n(50);
    chk_act("R10 link", 0);

    // R11: underflow
    mem_hold = 1'b1;
    wr_nn(dbase(1));
    pulse_vs(); wait_n(5);
    pulse_vs(); wait_n(3);
    chk("R11 uf set", {31'h0, underflow}, 32'h1);
    chk_act("R11 kept", 0);
    chk("R11 refetch", {31'h0, mem_req}, 32'h1);
    mem_hold = 1'b0;
    wait_n(50);
    chk_act("R11 done", 1);
    chk("R11 uf clear", {31'h0, underflow}, 32'h0);

    // R8: misaligned pointer
    wr_nn(dbase(1) + 32'h4);
    pulse_vs(); wait_n(5);
    chk("R8 err", {31'h0, ptr_err}, 32'h1);
    chk("R8 en kept", {31'h0, act_en}, 32'h1);
    chk("R8 no req", {31'h0, mem_req}, 32'h0);
    chk_act("R8 kept", 1);
    wr_nn(dbase(0));
    pulse_vs(); wait_n(50);
    chk("R8 err clear", {31'h0, ptr_err}, 32'h0);
    chk_act("R8 recover", 0);

    // R7: zero pointer
    wr_nn(32'h0);
    pulse_vs(); wait_n(5);
    chk("R7 en off", {31'h0, act_en}, 32'h0);
    chk("R7 no req", {31'h0, mem_req}, 32'h0);
    chk_act("R7 kept", 0);

    // R4: size sweep
    begin
      logic [15:0] vals [6];
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h07FE;
      vals[3] = 16'h07FF; vals[4] = 16'h0800; vals[5] = 16'hFFFF;
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          e_siz[0] = {vals[a], vals[b]};
          put_desc(0);
          wr_nn(dbase(0));
          pulse_vs(); wait_n(50);
          chk("R4 w", {16'h0, act_w}, {16'h0, clampx(vals[b])});
          chk("R4 h", {16'h0, act_h}, {16'h0, clampx(vals[a])});
        end
      end
    end

    // R5: priority sweep
    begin
      logic [31:0] pv [6];
      pv[0] = 32'h0; pv[1] = 32'h1; pv[2] = 32'h2;
      pv[3] = 32'h3; pv[4] = 32'h4; pv[5] = 32'hFFFF_FFFC;
      for (int p = 0; p < 6; p++) begin
        e_pri[0] = pv[p];
        put_desc(0);
        wr_nn(dbase(0));
        pulse_vs(); wait_n(50);
        chk("R5 en", {31'h0, act_en}, {31'h0, (pv[p][1:0] == 2'b00)});
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule